// File: doc/BRIEF.md
# Integer ALU with Flags

This block is the combinational arithmetic-logic unit of a 32-bit RISC integer datapath. Two operands, a shift distance and a 4-bit operation code come in. A result word, a signed-overflow flag and an all-zero flag go out in the same cycle. Thirteen operations are available: four bitwise functions, signed and unsigned add and subtract, signed and unsigned set-on-less-than, and three shifts of the second operand.

One adder serves every arithmetic and comparison operation. The shifter is a logarithmic barrel that handles left shifts by reversing bits on entry and on exit. Codes outside the thirteen defined ones produce a quiet all-zero result. The operand width is a parameter, and the shift-amount width is derived from it.

Top module: `int_alu`

## Requirements
- R1: Codes 0000, 0001, 0010 and 0011 give the bitwise AND, OR, XOR and NOR of A and B over all 32 bits.
- R2: Codes 0100 (signed) and 0101 (unsigned) give A plus B, modulo 2^32.
- R3: The overflow output is high only for codes 0100 and 0110, and only when the two's-complement sum or difference does not fit in 32 bits. For every other code it is low.
- R4: Codes 0110 (signed) and 0111 (unsigned) give A minus B, modulo 2^32.
- R5: Code 1000 puts 1 in result bit 0 when A is less than B as signed numbers, and 0 otherwise. Bits 31..1 are zero. The answer stays correct when A minus B overflows.
- R6: Code 1001 does the same comparison with A and B taken as unsigned numbers.
- R7: Code 1010 shifts B left by the shift amount (0..31) and fills with zeros. A is ignored.
- R8: Code 1011 shifts B right by the shift amount and fills with zeros.
- R9: Code 1100 shifts B right by the shift amount and copies bit 31 of B into every vacated position.
- R10: Codes 1101, 1110 and 1111 give an all-zero result with overflow low.
- R11: The zero output is high exactly when the 32-bit result is all zeros, for every code.
- R12: With a shift amount of 0, every shift code returns B unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand (minuend, left side of compare) |
| opnd_b | input | 32 | Second operand; also the value that shifts act on |
| shamt | input | 5 | Shift distance, 0 to 31 |
| op_sel | input | 4 | Operation code |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed overflow of signed add or subtract |
| zero | output | 1 | High when result is all zeros |

## Verification
The bench builds the unit with the default width of 32, so the shift amount is 5 bits wide. This brings the extremes of the shifter within reach: distances of 0 and 31, and sign fill across the whole word. It also reaches the 2^31 boundaries, where signed add, signed subtract and signed compare overflow. A hand-checked table covers these boundaries. A sweep over every code, including the three reserved ones, compares against a wide-integer model computed in the bench.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND   = 4'd0,
        OP_OR    = 4'd1,
        OP_XOR   = 4'd2,
        OP_NOR   = 4'd3,
        OP_ADD_S = 4'd4,
        OP_ADD_U = 4'd5,
        OP_SUB_S = 4'd6,
        OP_SUB_U = 4'd7,
        OP_LT_S  = 4'd8,
        OP_LT_U  = 4'd9,
        OP_SHL   = 4'd10,
        OP_SHR_L = 4'd11,
        OP_SHR_A = 4'd12
    } alu_op_e;

    typedef enum logic [1:0] {
        BIT_AND = 2'd0,
        BIT_OR  = 2'd1,
        BIT_XOR = 2'd2,
        BIT_NOR = 2'd3
    } bit_fn_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2
    } shift_mode_e;

endpackage

// File: rtl/int_alu_bitwise.sv
module int_alu_bitwise
    import int_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  bit_fn_e      fn,
    output logic [W-1:0] y
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            case (fn)
                BIT_AND: y[i] = a[i] & b[i];
                BIT_OR:  y[i] = a[i] | b[i];
                BIT_XOR: y[i] = a[i] ^ b[i];
                default: y[i] = ~(a[i] | b[i]);
            endcase
        end
    end

endmodule

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         sovf
);

    logic [W-1:0] b_eff;
    logic [W:0]   full;

    always_comb begin
        b_eff = sub ? ~b : b;
        full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = full[W-1:0];
        carry = full[W];
        // operands of equal sign giving a result of the other sign
        sovf  = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);
    end

endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift
    import int_alu_pkg::*;
#(
    parameter int W   = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   b,
    input  logic [SHW-1:0] amt,
    input  shift_mode_e    mode,
    output logic [W-1:0]   y
);

    function automatic logic [W-1:0] flip(input logic [W-1:0] v);
        logic [W-1:0] r;
        for (int k = 0; k < W; k++) r[k] = v[W-1-k];
        return r;
    endfunction

    logic            go_left;
    logic            fill;
    logic [W-1:0]    stage [SHW+1];

    assign go_left  = (mode == SH_LEFT);
    assign fill     = (mode == SH_RARI) && b[W-1];
    assign stage[0] = go_left ? flip(b) : b;

    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int STEP = 1 << i;
        assign stage[i+1] = amt[i] ? {{STEP{fill}}, stage[i][W-1:STEP]}
                                   : stage[i];
    end

    assign y = go_left ? flip(stage[SHW]) : stage[SHW];

endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int W   = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   opnd_a,
    input  logic [W-1:0]   opnd_b,
    input  logic [SHW-1:0] shamt,
    input  logic [3:0]     op_sel,
    output logic [W-1:0]   result,
    output logic           ovf,
    output logic           zero
);

    typedef struct packed {
        logic [W-1:0] data;
        logic         ovf;
    } alu_out_t;

    alu_op_e      op;
    logic         sub_en;
    logic [W-1:0] logic_y;
    logic [W-1:0] sum;
    logic         carry;
    logic         sovf;
    shift_mode_e  sh_mode;
    logic [W-1:0] shift_y;
    alu_out_t     out_d;

    assign op = alu_op_e'(op_sel);

    always_comb begin
        sub_en = (op == OP_SUB_S) || (op == OP_SUB_U) ||
                 (op == OP_LT_S)  || (op == OP_LT_U);
        case (op)
            OP_SHR_L: sh_mode = SH_RLOG;
            OP_SHR_A: sh_mode = SH_RARI;
            default:  sh_mode = SH_LEFT;
        endcase
    end

    int_alu_bitwise #(.W(W)) i_bitwise (
        .a  (opnd_a),
        .b  (opnd_b),
        .fn (bit_fn_e'(op_sel[1:0])),
        .y  (logic_y)
    );

    int_alu_addsub #(.W(W)) i_addsub (
        .a     (opnd_a),
        .b     (opnd_b),
        .sub   (sub_en),
        .sum   (sum),
        .carry (carry),
        .sovf  (sovf)
    );

    int_alu_shift #(.W(W)) i_shift (
        .b    (opnd_b),
        .amt  (shamt),
        .mode (sh_mode),
        .y    (shift_y)
    );

    always_comb begin
        out_d = '0;
        case (op)
            OP_AND, OP_OR, OP_XOR, OP_NOR: out_d.data = logic_y;
            OP_ADD_S, OP_SUB_S: begin
                out_d.data = sum;
                out_d.ovf  = sovf;
            end
            OP_ADD_U, OP_SUB_U: out_d.data = sum;
            // sign of the true difference: sum sign corrected by overflow
            OP_LT_S: out_d.data = {{(W-1){1'b0}}, sum[W-1] ^ sovf};
            // no carry out of a - b means a borrow was taken
            OP_LT_U: out_d.data = {{(W-1){1'b0}}, ~carry};
            OP_SHL, OP_SHR_L, OP_SHR_A: out_d.data = shift_y;
            default: out_d = '0;
        endcase
    end

    assign result = out_d.data;
    assign ovf    = out_d.ovf;
    assign zero   = ~|out_d.data;

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
    parameter int W   = 32,
    localparam int SHW = $clog2(W)
) (
    input logic [W-1:0]   a,
    input logic [W-1:0]   b,
    input logic [SHW-1:0] shamt,
    input logic [3:0]     op_sel,
    input logic [W-1:0]   result,
    input logic           ovf,
    input logic           zero
);

    always_comb begin
        if (op_sel != 4'd4 && op_sel != 4'd6)
            assert_no_overflow_R3: assert (!ovf);
        if (op_sel == 4'd8 || op_sel == 4'd9)
            assert_lt_upper_clear_R5: assert (result[W-1:1] == '0);
        if (op_sel >= 4'd13)
            assert_reserved_quiet_R10: assert (result == '0 && !ovf);
        if (op_sel == 4'd2 && a == b)
            assert_xor_self_zero_R11: assert (zero);
        if (op_sel == 4'd10 && shamt != '0)
            assert_shl_low_clear_R7: assert (!result[0]);
        if (op_sel == 4'd12)
            assert_sra_sign_kept_R9: assert (result[W-1] == b[W-1]);
        if (op_sel >= 4'd10 && op_sel <= 4'd12 && shamt == '0)
            assert_shift_zero_pass_R12: assert (result == b);
    end

endmodule

bind int_alu int_alu_chk #(.W(W)) i_chk (
    .a      (opnd_a),
    .b      (opnd_b),
    .shamt  (shamt),
    .op_sel (op_sel),
    .result (result),
    .ovf    (ovf),
    .zero   (zero)
);

// File: tb/test_int_alu.sv
module test_int_alu;

    localparam int W     = 32;
    localparam int SHW   = 5;
    localparam int NVEC  = 25;
    localparam int NRAND = 400;

    typedef struct packed {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [4:0]  sh;
        logic [31:0] res;
        logic        ovf;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  32'hF0F000FF, 32'h0FF00F0F, 5'd0,  32'h00F0000F, 1'b0},
        '{4'd1,  32'hF0F000FF, 32'h0FF00F0F, 5'd0,  32'hFFF00FFF, 1'b0},
        '{4'd2,  32'hF0F000FF, 32'h0FF00F0F, 5'd0,  32'hFF000FF0, 1'b0},
        '{4'd3,  32'hF0F000FF, 32'h0FF00F0F, 5'd0,  32'h000FF000, 1'b0},
        '{4'd4,  32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h80000000, 1'b1},
        '{4'd5,  32'h7FFFFFFF, 32'h00000001, 5'd0,  32'h80000000, 1'b0},
        '{4'd4,  32'hFFFFFFFF, 32'h00000001, 5'd0,  32'h00000000, 1'b0},
        '{4'd5,  32'hFFFFFFFF, 32'h00000002, 5'd0,  32'h00000001, 1'b0},
        '{4'd6,  32'h80000000, 32'h00000001, 5'd0,  32'h7FFFFFFF, 1'b1},
        '{4'd7,  32'h00000005, 32'h00000007, 5'd0,  32'hFFFFFFFE, 1'b0},
        '{4'd6,  32'h12345678, 32'h12345678, 5'd0,  32'h00000000, 1'b0},
        '{4'd8,  32'h80000000, 32'h00000001, 5'd0,  32'h00000001, 1'b0},
        '{4'd8,  32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0,  32'h00000000, 1'b0},
        '{4'd9,  32'h80000000, 32'h00000001, 5'd0,  32'h00000000, 1'b0},
        '{4'd9,  32'h00000001, 32'hFFFFFFFF, 5'd0,  32'h00000001, 1'b0},
        '{4'd9,  32'h00000005, 32'h00000005, 5'd0,  32'h00000000, 1'b0},
        '{4'd10, 32'hDEADBEEF, 32'h80000001, 5'd1,  32'h00000002, 1'b0},
        '{4'd10, 32'hDEADBEEF, 32'h00000001, 5'd31, 32'h80000000, 1'b0},
        '{4'd11, 32'hDEADBEEF, 32'h80000000, 5'd31, 32'h00000001, 1'b0},
        '{4'd12, 32'hDEADBEEF, 32'h80000000, 5'd31, 32'hFFFFFFFF, 1'b0},
        '{4'd12, 32'hDEADBEEF, 32'h40000000, 5'd30, 32'h00000001, 1'b0},
        '{4'd12, 32'hDEADBEEF, 32'h80001234, 5'd0,  32'h80001234, 1'b0},
        '{4'd11, 32'hDEADBEEF, 32'hF000000F, 5'd4,  32'h0F000000, 1'b0},
        '{4'd13, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd3,  32'h00000000, 1'b0},
        '{4'd15, 32'h7FFFFFFF, 32'h00000001, 5'd7,  32'h00000000, 1'b0}
    };

    logic           clk;
    logic           rst;
    logic [W-1:0]   opnd_a;
    logic [W-1:0]   opnd_b;
    logic [SHW-1:0] shamt;
    logic [3:0]     op_sel;
    logic [W-1:0]   result;
    logic           ovf;
    logic           zero;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    int_alu #(.W(W)) i_int_alu (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .shamt  (shamt),
        .op_sel (op_sel),
        .result (result),
        .ovf    (ovf),
        .zero   (zero)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1, 4'd2, 4'd3: return "R1";
            4'd4, 4'd5:             return "R2";
            4'd6, 4'd7:             return "R4";
            4'd8:                   return "R5";
            4'd9:                   return "R6";
            4'd10:                  return "R7";
            4'd11:                  return "R8";
            4'd12:                  return "R9";
            default:                return "R10";
        endcase
    endfunction

    // wide-integer reference built from the requirement text
    function automatic logic [32:0] model(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [4:0] sh);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint t;
        logic [31:0] r = '0;
        logic o = 1'b0;
        case (op)
            4'd0: r = a & b;
            4'd1: r = a | b;
            4'd2: r = a ^ b;
            4'd3: r = ~(a | b);
            4'd4, 4'd5: begin
                r = a + b;
                t = sa + sb;
                o = (op == 4'd4) && (t > 64'sd2147483647 || t < -64'sd2147483648);
            end
            4'd6, 4'd7: begin
                r = a - b;
                t = sa - sb;
                o = (op == 4'd6) && (t > 64'sd2147483647 || t < -64'sd2147483648);
            end
            4'd8:  r = {31'd0, sa < sb};
            4'd9:  r = {31'd0, a < b};
            4'd10: r = b << sh;
            4'd11: r = b >> sh;
            4'd12: r = 32'($signed(b) >>> sh);
            default: r = '0;
        endcase
        return {o, r};
    endfunction

    task automatic apply(input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] sh);
        @(posedge clk);
        #1;
        op_sel = op; opnd_a = a; opnd_b = b; shamt = sh;
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] er, input logic eo);
        n_checks++;
        if (result !== er) begin
            n_fails++;
            $display("FAIL %s result op=%0d: actual %h expected %h", tag, op_sel, result, er);
        end
        n_checks++;
        if (ovf !== eo) begin
            n_fails++;
            $display("FAIL R3 ovf op=%0d: actual %b expected %b", op_sel, ovf, eo);
        end
        n_checks++;
        if (zero !== (er == '0)) begin
            n_fails++;
            $display("FAIL R11 zero op=%0d: actual %b expected %b", op_sel, zero, er == '0);
        end
    endtask

    initial begin
        logic [32:0] m;
        rst = 1'b1;
        op_sel = '0; opnd_a = '0; opnd_b = '0; shamt = '0;
        repeat (3) @(posedge clk);
        #1;
        // reset state: all-zero inputs give an all-zero AND result
        check("R11", 32'h0, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].sh);
            check(tag_of(VECS[i].op), VECS[i].res, VECS[i].ovf);
        end

        // R12: zero distance passes B through on each shift code
        for (int op = 10; op <= 12; op++) begin
            apply(4'(op), 32'h0BADF00D, 32'hC001D00D, 5'd0);
            check("R12", 32'hC001D00D, 1'b0);
        end

        // R9: sign fill on a negative value at mid distance
        apply(4'd12, 32'h0, 32'hF0000000, 5'd8);
        check("R9", 32'hFFF00000, 1'b0);

        // R3: unsigned subtract across the signed boundary stays quiet
        apply(4'd7, 32'h80000000, 32'h00000001, 5'd0);
        check("R3", 32'h7FFFFFFF, 1'b0);

        // R10: reserved code 14 with inputs that would otherwise be nonzero
        apply(4'd14, 32'h80000000, 32'h80000000, 5'd1);
        check("R10", 32'h0, 1'b0);

        // sweep every code against the reference
        for (int i = 0; i < NRAND; i++) begin
            logic [31:0] ra = $urandom;
            logic [31:0] rb = $urandom;
            logic [3:0]  ro = 4'(i % 16);
            logic [4:0]  rs = 5'($urandom);
            if (i % 5 == 0) rb = ra;
            if (i % 7 == 0) ra = {ra[31], 31'h7FFFFFFF};
            apply(ro, ra, rb, rs);
            m = model(ro, ra, rb, rs);
            check(tag_of(ro), m[31:0], m[32]);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule